// File: doc/BRIEF.md
# Frame Triplet Capture Sequencer

This block runs on the device side of a frame grabber whose camera delivers video frames in groups of three. Each arriving frame is presented on a valid/ready strobe that carries its position inside the group (0, 1 or 2). The sequencer admits frames strictly in group order and holds one frame at a time as "pending" until an external DMA engine reports with a one-cycle pulse that the transfer to host memory has finished. It then flags the completion and, if the group was interrupted by the start of a new one, counts the lost group.

The host sees four 32-bit words through a simple synchronous register port: the frame size in 4096-byte pages, a control word whose bit 0 enables capture and the interrupt, a status word packing the pending frame number, the completion flag and the lost-group counter, and a word reporting whether the hand-held accessory is connected. An interrupt line is raised while there is something to report. Clearing the enable discards all partial progress, so capture always restarts at the first frame of a group.

Frame handshake rules: a frame is consumed in a cycle where `frm_valid` and `frm_ready` are both high. `frm_ready` is low only while capture is enabled and a frame is still pending; while capture is disabled every offered frame is consumed and thrown away. A consumed frame whose position does not fit the expected order is thrown away with no effect.

Top module: `triplet_seq`

## Requirements
- R1: Word 0 reads the frame size parameter `FRAME_PAGES` (count of 4096-byte pages); writes to word 0, 2 and 3 change nothing.
- R2: Word 1 bit 0 is the enable; it resets to 0 and reads back the last value written.
- R3: With capture enabled, a consumed frame at position 0 makes the status bits 1:0 read 1; afterwards only the next position in order (1, then 2, each after the previous frame's completion) is taken and reads 2, then 3; any other position is discarded with no effect.
- R4: `frm_ready` is low while capture is enabled and a frame is pending, and high otherwise.
- R5: A `dma_done` pulse while a frame is pending clears status bits 1:0 to 0 and sets status bit 2; bit 2 clears when the next frame is taken; a `dma_done` pulse with nothing pending has no effect.
- R6: Status bits 15:8 count lost groups: one is added when a position-0 frame is taken after one or two frames of the current group were completed but not all three; the count saturates at 255.
- R7: A read of word 2 returns the count before clearing and sets it to 0 on that clock edge.
- R8: Writing 0 to the enable clears the pending frame, the completion flag and the group progress; frames offered while disabled are consumed and ignored; after re-enabling, only a position-0 frame is taken first.
- R9: `irq` is high exactly when capture is enabled and a frame is pending or the completion flag is set.
- R10: Word 2 reads all zeros when nothing is pending, no completion is flagged and no group was lost.
- R11: Word 3 bit 0 reflects `acc_present` (1 = connected); all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_valid | input | 1 | A frame is offered |
| frm_ready | output | 1 | The offered frame is consumed this cycle |
| frm_pos | input | 2 | Position of the offered frame inside its group (0 to 2) |
| dma_done | input | 1 | One-cycle pulse: the pending frame's transfer finished |
| acc_present | input | 1 | Accessory connected |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears the lost-group count on word 2) |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid in the cycle of the address |
| irq | output | 1 | Interrupt request toward the host |

## Verification
The main sequence is driven with a clean in-order group, with frames offered while one is still pending (back-pressure must hold them off), and with positions out of order, which must leave the status untouched and so separate order checking from mere acceptance. Interrupted groups are produced after one and after two completed frames, then repeated past 255 to separate counting from saturation, with reads between them showing the clear-on-read value. Disabling in the middle of a group and re-enabling with a non-zero position first shows that progress was flushed rather than kept.

// File: rtl/tseq_pkg.sv
package tseq_pkg;
  localparam int GRP_LEN = 3;
  localparam int POS_W   = $clog2(GRP_LEN + 1);
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    W_SIZE = 2'd0,
    W_CTRL = 2'd1,
    W_STAT = 2'd2,
    W_ACC  = 2'd3
  } reg_word_e;
endpackage

// File: rtl/tseq_track.sv
module tseq_track
  import tseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             frm_valid,
  input  logic [POS_W-1:0] frm_pos,
  input  logic             dma_done,
  output logic             frm_ready,
  output logic [POS_W-1:0] pend,
  output logic             cmp,
  output logic             lost_evt
);
  // frames of the current group already transferred
  logic [POS_W-1:0] prog;
  logic             take, start, cont;

  assign frm_ready = !en || (pend == '0);
  assign take      = frm_valid && frm_ready && en;
  assign start     = take && (frm_pos == '0);
  assign cont      = take && (prog != '0) && (frm_pos == prog);
  assign lost_evt  = start && (prog != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      prog <= '0;
      cmp  <= 1'b0;
    end else if (!en) begin
      pend <= '0;
      prog <= '0;
      cmp  <= 1'b0;
    end else if (start) begin
      pend <= POS_W'(1);
      prog <= '0;
      cmp  <= 1'b0;
    end else if (cont) begin
      pend <= frm_pos + POS_W'(1);
      cmp  <= 1'b0;
    end else if (dma_done && (pend != '0)) begin
      cmp  <= 1'b1;
      pend <= '0;
      prog <= (pend == POS_W'(GRP_LEN)) ? '0 : pend;
    end
  end

  p_order_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pend != '0 && $past(pend) == '0) |->
      (pend == POS_W'(1) || pend == $past(prog) + POS_W'(1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pend != '0 && !dma_done) |=> (pend == $past(pend)));

  p_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_done && pend != '0) |=> (pend == '0 && cmp));

  p_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (pend == '0 && !cmp && prog == '0));
endmodule

// File: rtl/tseq_sat_ctr.sv
module tseq_sat_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] MAX = {W{1'b1}};
  logic [W-1:0] base;

  assign base = clr ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt <= '0;
    else if (inc && base != MAX)  cnt <= base + W'(1);
    else                          cnt <= base;
  end

  p_sat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == MAX && !clr) |=> (cnt == MAX));

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !inc) |=> (cnt == '0));
endmodule

// File: rtl/tseq_regs.sv
module tseq_regs
  import tseq_pkg::*;
#(
  parameter int FRAME_PAGES = 600,
  parameter int LOST_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [POS_W-1:0]  pend,
  input  logic              cmp,
  input  logic [LOST_W-1:0] lost_cnt,
  input  logic              acc_present,
  output logic              en,
  output logic              stat_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int CMP_BIT  = 2;
  localparam int LOST_LSB = 8;

  reg_word_e  word;
  logic       unused_wdata;

  assign word         = reg_word_e'(reg_addr);
  assign stat_rd      = reg_rd && (word == W_STAT);
  assign unused_wdata = ^reg_wdata[DATA_W-1:1];

  always_ff @(posedge clk) begin
    if (!rst_n)                        en <= 1'b0;
    else if (reg_wr && word == W_CTRL) en <= reg_wdata[0];
  end

  always_comb begin
    reg_rdata = '0;
    case (word)
      W_SIZE: reg_rdata = DATA_W'(FRAME_PAGES);
      W_CTRL: reg_rdata[0] = en;
      W_STAT: begin
        reg_rdata[POS_W-1:0]          = pend;
        reg_rdata[CMP_BIT]            = cmp;
        reg_rdata[LOST_LSB +: LOST_W] = lost_cnt;
      end
      default: reg_rdata[0] = acc_present;
    endcase
  end

  p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && word == W_CTRL) |=> (en == $past(en)));
endmodule

// File: rtl/triplet_seq.sv
module triplet_seq
  import tseq_pkg::*;
#(
  parameter int FRAME_PAGES = 600,
  parameter int LOST_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [POS_W-1:0]  frm_pos,
  input  logic              dma_done,
  input  logic              acc_present,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic              en, cmp, lost_evt, stat_rd;
  logic [POS_W-1:0]  pend;
  logic [LOST_W-1:0] lost_cnt;

  tseq_track u_track (
    .clk(clk), .rst_n(rst_n), .en(en),
    .frm_valid(frm_valid), .frm_pos(frm_pos), .dma_done(dma_done),
    .frm_ready(frm_ready), .pend(pend), .cmp(cmp), .lost_evt(lost_evt)
  );

  tseq_sat_ctr #(.W(LOST_W)) u_lost (
    .clk(clk), .rst_n(rst_n), .inc(lost_evt), .clr(stat_rd), .cnt(lost_cnt)
  );

  tseq_regs #(.FRAME_PAGES(FRAME_PAGES), .LOST_W(LOST_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend(pend), .cmp(cmp),
    .lost_cnt(lost_cnt), .acc_present(acc_present), .en(en),
    .stat_rd(stat_rd), .reg_rdata(reg_rdata)
  );

  assign irq = en && ((pend != '0) || cmp);

  p_lost_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |-> (en && frm_valid && frm_pos == '0));
endmodule

// File: tb/triplet_seq_tb.sv
module triplet_seq_tb;
  localparam int PAGES = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [1:0]  frm_pos = 2'd0;
  logic        dma_done = 1'b0;
  logic        acc_present = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  triplet_seq #(.FRAME_PAGES(PAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_pos(frm_pos), .dma_done(dma_done), .acc_present(acc_present),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input logic [1:0] p, output logic rdy);
    @(negedge clk);
    frm_pos = p; frm_valid = 1'b1;
    #1 rdy = frm_ready;
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic done();
    @(negedge clk);
    dma_done = 1'b1;
    @(negedge clk);
    dma_done = 1'b0;
  endtask

  task automatic stat_is(input string req, input logic [31:0] exp);
    logic [31:0] d;
    rd(2'd2, d);
    check(req, d, exp);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check("R9 irq at reset", {31'd0, irq}, 32'd0);
    check("R4 ready when disabled", {31'd0, frm_ready}, 32'd1);
    stat_is("R10 status zero at reset", 32'd0);
    rd(2'd1, d); check("R2 enable resets to 0", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    rd(2'd0, d); check("R1 frame size", d, PAGES);
    wr(2'd0, 32'd5);
    rd(2'd0, d); check("R1 size write ignored", d, PAGES);
    wr(2'd2, 32'hFFFF_FFFF);
    stat_is("R1 status write ignored", 32'd0);
    acc_present = 1'b1;
    rd(2'd3, d); check("R11 accessory present", d, 32'd1);
    acc_present = 1'b0;
    rd(2'd3, d); check("R11 accessory absent", d, 32'd0);
    wr(2'd1, 32'd1);
    rd(2'd1, d); check("R2 enable reads back", d, 32'd1);
    stat_is("R10 status zero after enable", 32'd0);
    #1 check("R9 irq idle", {31'd0, irq}, 32'd0);
  endtask

  task automatic t_in_order();
    logic r;
    send(2'd0, r); check("R4 ready idle", {31'd0, r}, 32'd1);
    stat_is("R3 first frame pending", 32'd1);
    #1 check("R9 irq pending", {31'd0, irq}, 32'd1);
    send(2'd1, r); check("R4 ready low while pending", {31'd0, r}, 32'd0);
    stat_is("R4 held frame not taken", 32'd1);
    done();
    stat_is("R5 completion flag", 32'd4);
    #1 check("R9 irq on completion", {31'd0, irq}, 32'd1);
    send(2'd1, r);
    stat_is("R3 second frame pending", 32'd2);
    done();
    send(2'd2, r);
    stat_is("R3 third frame pending", 32'd3);
    done();
    stat_is("R5 group complete", 32'd4);
    done();
    stat_is("R5 done with nothing pending ignored", 32'd4);
  endtask

  task automatic t_out_of_order();
    logic r;
    send(2'd2, r);
    stat_is("R3 pos2 out of order ignored", 32'd4);
    send(2'd1, r);
    stat_is("R3 pos1 out of order ignored", 32'd4);
    send(2'd0, r);
    stat_is("R3 restart after full group, no loss", 32'd1);
    done();
    send(2'd2, r);
    stat_is("R3 skipped position ignored", 32'd4);
    send(2'd1, r);
    stat_is("R3 in-order second frame", 32'd2);
    done();
  endtask

  task automatic t_lost();
    logic r;
    send(2'd0, r);
    stat_is("R6 loss after two frames", 32'h101);
    stat_is("R7 cleared by read", 32'h001);
    done();
    send(2'd0, r);
    rd(2'd2, reg_wdata);
    check("R6 loss after one frame", reg_wdata, 32'h101);
    reg_wdata = 32'd0;
    stat_is("R7 cleared again", 32'h001);
  endtask

  task automatic t_saturate();
    logic r;
    for (int i = 0; i < 300; i++) begin
      done();
      send(2'd0, r);
    end
    stat_is("R6 count saturates at 255", 32'hFF01);
    stat_is("R7 saturated count cleared", 32'h0001);
  endtask

  task automatic t_disable();
    logic r;
    done();
    stat_is("R5 completion before disable", 32'd4);
    wr(2'd1, 32'd0);
    stat_is("R8 disable flushes", 32'd0);
    #1 check("R9 irq low when disabled", {31'd0, irq}, 32'd0);
    send(2'd0, r); check("R8 frame consumed while disabled", {31'd0, r}, 32'd1);
    stat_is("R8 frame ignored while disabled", 32'd0);
    wr(2'd1, 32'd1);
    send(2'd1, r);
    stat_is("R8 resume needs first frame", 32'd0);
    send(2'd0, r);
    stat_is("R8 resume at first frame, no loss", 32'd1);
  endtask

  initial begin
    t_reset();
    t_regs();
    t_in_order();
    t_out_of_order();
    t_lost();
    t_saturate();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule